// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Manager

This block keeps an asynchronous DRAM's contents alive. After reset it waits a long, programmable pause and then runs a burst of initialization refresh cycles. Only when that burst is complete does it report that the memory may be used. From then on an interval timer produces one refresh obligation per period. The obligations collect in a small saturating counter, so the access sequencer can postpone several of them and the block later catches up. Each refresh is a CAS-before-RAS cycle that relies on the memory's own row counter. A parameter selects a RAS-only variant instead, in which the block drives the row address from its own counter and leaves CAS high.

The block shares the DRAM pins with an access sequencer through a request/grant pair. It raises `ref_req`, waits for `ref_gnt`, and then drives RAS and both CAS strobes itself until it drops the request. It also handles a self-refresh handshake:

- **Entry.** The block enters self-refresh once the sequencer reports idle and no refresh is owed. It then holds a CAS-before-RAS cycle with RAS low. After the minimum hold time it acknowledges.
- **Exit.** When the request falls, the block releases the strobes and waits out the extended precharge. It then issues the refresh the memory needs on leaving self-refresh.
- **RAS-only mode.** A full pass over all rows runs before entry and again after exit.

All timings are parameters in clock cycles. The write-enable strobe is held inactive (high).

Top module: `dram_refresh_mgr`

## Requirements
- R1: After reset RAS, both CAS strobes and `ref_req` are high, high, high and low, and `init_done` is low. No strobe moves during the first `INIT_WAIT_CYC` cycles.
- R2: After the pause, exactly `INIT_CYCLES` (8) refresh cycles are issued, and then `init_done` rises.
- R3: In a CAS-before-RAS cycle both CAS strobes fall together at least `CAS_SETUP_CYC` cycles before RAS falls. They stay low while RAS is low. RAS stays low at least `RAS_LOW_CYC` cycles.
- R4: While `ref_gnt` is withheld, no strobe moves and `ref_req` stays high.
- R5: After initialization, one refresh is owed every `INTERVAL_CYC` cycles. With the grant always given, a window of 10 intervals holds 9 to 11 refresh cycles.
- R6: Owed refreshes saturate at `OWED_MAX` (8). After a long withheld grant, at most one more refresh than that is issued once the grant returns.
- R7: With `RAS_ONLY`=1, refresh cycles keep both CAS strobes high. They present row addresses 0, 1, 2, … in order, wrapping after `ROWS`-1.
- R8: Self-refresh starts only while `seq_idle` is high. RAS is low with CAS low for at least `SR_MIN_CYC` cycles before `self_refresh_ack` rises. No further RAS edge occurs while the acknowledge is held.
- R9: When `self_refresh_req` falls, RAS rises as the acknowledge falls. RAS then stays high at least `SR_EXIT_CYC` cycles, and exactly one refresh cycle follows with `ref_req` held throughout. The request is then released.
- R10: With `RAS_ONLY`=1, a full pass of `ROWS` RAS-only cycles precedes self-refresh entry, and another full pass follows exit.
- R11: The owed-refresh count never exceeds `OWED_MAX`.
- R12: `ref_req` stays high across the whole initialization burst. The strobes are low only while `ref_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ref_req | output | 1 | Request for ownership of the DRAM strobes |
| ref_gnt | input | 1 | Ownership granted by the access sequencer |
| seq_idle | input | 1 | Access sequencer has no work in progress |
| self_refresh_req | input | 1 | Ask to enter (high) or leave (low) self-refresh |
| self_refresh_ack | output | 1 | Memory is in self-refresh |
| init_done | output | 1 | Power-up sequence finished; accesses allowed |
| ras_n | output | 1 | Row strobe, active low |
| ucas_n | output | 1 | Upper column strobe, active low |
| lcas_n | output | 1 | Lower column strobe, active low |
| we_n | output | 1 | Write enable, held high |
| row_addr | output | ROW_W | Row address for RAS-only refresh |

## Verification
The bench drives the block with four grant patterns:

- **Always granted.** This measures the steady refresh rate over a ten-interval window.
- **Grant withheld for twelve intervals.** This tells a saturating owed count apart from one that wraps or keeps counting, since the catch-up burst must be 8 or 9 cycles long.
- **Self-refresh request while the sequencer is busy.** This separates correct gating on `seq_idle` from eager entry.
- **Self-refresh request with the sequencer idle.** The bench checks the hold time, the exit precharge and the single follow-up cycle.

A second instance in RAS-only mode checks the row order and the full passes around self-refresh. Its counts would differ from those of the CAS-before-RAS instance if the mode leaked into the cycle shape.

// File: rtl/rfm_pkg.sv
package rfm_pkg;

    typedef enum logic [2:0] {
        ST_PWRUP,
        ST_IDLE,
        ST_REQ,
        ST_SETUP,
        ST_RASLO,
        ST_PRECH
    } rfm_state_e;

    typedef enum logic {
        KIND_REF,
        KIND_SR
    } rfm_kind_e;

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rfm_interval_timer.sv
module rfm_interval_timer #(
    parameter int unsigned INTERVAL_CYC = 3900
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    output logic tick
);
    localparam int unsigned TW = (INTERVAL_CYC > 2) ? $clog2(INTERVAL_CYC) : 1;

    logic [TW-1:0] cnt_d, cnt_q;
    logic          wrap;

    always_comb begin
        wrap  = (cnt_q == TW'(INTERVAL_CYC - 1));
        cnt_d = cnt_q;
        if (hold)      cnt_d = '0;
        else if (wrap) cnt_d = '0;
        else           cnt_d = cnt_q + 1'b1;
    end

    assign tick = wrap && !hold;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/rfm_owed_counter.sv
module rfm_owed_counter #(
    parameter int unsigned OWED_MAX = 8,
    localparam int unsigned OW = $clog2(OWED_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          dec,
    output logic [OW-1:0] count,
    output logic          nonzero
);
    logic [OW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc && !dec) begin
            if (cnt_q < OW'(OWED_MAX)) cnt_d = cnt_q + 1'b1;
        end else if (dec && !inc) begin
            if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
        end
    end

    assign count   = cnt_q;
    assign nonzero = (cnt_q != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/rfm_row_counter.sv
module rfm_row_counter #(
    parameter int unsigned ROWS = 1024,
    localparam int unsigned RW = $clog2(ROWS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    output logic [RW-1:0] row
);
    logic [RW-1:0] row_d, row_q;

    always_comb begin
        row_d = row_q;
        if (adv) row_d = (row_q == RW'(ROWS - 1)) ? '0 : row_q + 1'b1;
    end

    assign row = row_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) row_q <= '0;
        else        row_q <= row_d;
    end
endmodule

// File: rtl/rfm_cycle_fsm.sv
module rfm_cycle_fsm
    import rfm_pkg::*;
#(
    parameter bit          RAS_ONLY      = 1'b0,
    parameter int unsigned INIT_WAIT_CYC = 50_000_000,
    parameter int unsigned INIT_CYCLES   = 8,
    parameter int unsigned CAS_SETUP_CYC = 3,
    parameter int unsigned RAS_LOW_CYC   = 15,
    parameter int unsigned PRECHARGE_CYC = 10,
    parameter int unsigned SR_MIN_CYC    = 25_000,
    parameter int unsigned SR_EXIT_CYC   = 28,
    parameter int unsigned ROWS          = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_gnt,
    input  logic seq_idle,
    input  logic sr_req,
    input  logic owed_nz,
    output logic ref_req,
    output logic ras_n,
    output logic cas_n,
    output logic sr_ack,
    output logic init_done,
    output logic timer_hold,
    output logic owed_dec,
    output logic row_adv
);
    localparam int unsigned CMAX = umax(umax(INIT_WAIT_CYC, SR_MIN_CYC),
                                        umax(umax(RAS_LOW_CYC, PRECHARGE_CYC),
                                             umax(CAS_SETUP_CYC, SR_EXIT_CYC)));
    localparam int unsigned CW     = $clog2(CMAX + 1);
    localparam int unsigned FW     = $clog2(umax(INIT_CYCLES, ROWS) + 1);
    localparam int unsigned PRE_N  = RAS_ONLY ? ROWS : 0;
    localparam int unsigned POST_N = RAS_ONLY ? ROWS : 1;

    typedef struct packed {
        rfm_state_e    st;
        rfm_kind_e     kind;
        logic          src_forced;
        logic          sr_arm;
        logic          ack;
        logic          done_init;
        logic [FW-1:0] forced;
        logic [CW-1:0] cnt;
        logic          ras_n;
        logic          cas_n;
    } fsm_s;

    fsm_s          q, d;
    logic [FW-1:0] forced_left;

    always_comb begin
        d           = q;
        owed_dec    = 1'b0;
        row_adv     = 1'b0;
        forced_left = q.forced;
        unique case (q.st)
            ST_PWRUP: begin
                if (q.cnt == '0) begin
                    d.st     = ST_IDLE;
                    d.forced = FW'(INIT_CYCLES);
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_IDLE: begin
                if (q.forced != '0) begin
                    d.st         = ST_REQ;
                    d.kind       = KIND_REF;
                    d.src_forced = 1'b1;
                end else if (owed_nz) begin
                    d.st         = ST_REQ;
                    d.kind       = KIND_REF;
                    d.src_forced = 1'b0;
                end else if (q.done_init && sr_req && seq_idle) begin
                    d.st     = ST_REQ;
                    d.sr_arm = 1'b1;
                    if (PRE_N != 0) begin
                        d.kind       = KIND_REF;
                        d.forced     = FW'(PRE_N);
                        d.src_forced = 1'b1;
                    end else begin
                        d.kind = KIND_SR;
                    end
                end
            end
            ST_REQ: begin
                if (ref_gnt) begin
                    d.st  = ST_SETUP;
                    d.cnt = CW'(CAS_SETUP_CYC - 1);
                end
            end
            ST_SETUP: begin
                if (q.cnt == '0) begin
                    d.st  = ST_RASLO;
                    d.cnt = (q.kind == KIND_SR) ? CW'(SR_MIN_CYC - 1) : CW'(RAS_LOW_CYC - 1);
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_RASLO: begin
                if (q.cnt != '0) begin
                    d.cnt = q.cnt - 1'b1;
                end else if (q.kind == KIND_REF) begin
                    d.st  = ST_PRECH;
                    d.cnt = CW'(PRECHARGE_CYC - 1);
                end else if (!q.ack) begin
                    d.ack = 1'b1;
                end else if (!sr_req) begin
                    d.ack = 1'b0;
                    d.st  = ST_PRECH;
                    d.cnt = CW'(SR_EXIT_CYC - 1);
                end
            end
            ST_PRECH: begin
                if (q.cnt != '0) begin
                    d.cnt = q.cnt - 1'b1;
                end else if (q.kind == KIND_SR) begin
                    d.kind       = KIND_REF;
                    d.sr_arm     = 1'b0;
                    d.forced     = FW'(POST_N);
                    d.src_forced = 1'b1;
                    d.st         = ST_SETUP;
                    d.cnt        = CW'(CAS_SETUP_CYC - 1);
                end else begin
                    row_adv = RAS_ONLY;
                    if (q.src_forced) forced_left = q.forced - 1'b1;
                    else              owed_dec    = 1'b1;
                    d.forced = forced_left;
                    if (forced_left == '0) d.done_init = 1'b1;
                    if (forced_left != '0) begin
                        d.st         = ST_SETUP;
                        d.src_forced = 1'b1;
                        d.cnt        = CW'(CAS_SETUP_CYC - 1);
                    end else if (q.sr_arm) begin
                        d.st   = ST_SETUP;
                        d.kind = KIND_SR;
                        d.cnt  = CW'(CAS_SETUP_CYC - 1);
                    end else begin
                        d.st = ST_IDLE;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
        d.ras_n = (d.st != ST_RASLO);
        d.cas_n = !(((d.st == ST_SETUP) || (d.st == ST_RASLO)) &&
                    ((d.kind == KIND_SR) || !RAS_ONLY));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q            <= '0;
            q.st         <= ST_PWRUP;
            q.kind       <= KIND_REF;
            q.cnt        <= CW'(INIT_WAIT_CYC - 1);
            q.ras_n      <= 1'b1;
            q.cas_n      <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign ref_req    = (q.st == ST_REQ) || (q.st == ST_SETUP) ||
                        (q.st == ST_RASLO) || (q.st == ST_PRECH);
    assign ras_n      = q.ras_n;
    assign cas_n      = q.cas_n;
    assign sr_ack     = q.ack;
    assign init_done  = q.done_init;
    assign timer_hold = !q.done_init || q.sr_arm || (q.kind == KIND_SR);
endmodule

// File: rtl/dram_refresh_mgr.sv
module dram_refresh_mgr #(
    parameter bit          RAS_ONLY      = 1'b0,
    parameter int unsigned INIT_WAIT_CYC = 50_000_000,
    parameter int unsigned INIT_CYCLES   = 8,
    parameter int unsigned INTERVAL_CYC  = 3900,
    parameter int unsigned OWED_MAX      = 8,
    parameter int unsigned CAS_SETUP_CYC = 3,
    parameter int unsigned RAS_LOW_CYC   = 15,
    parameter int unsigned PRECHARGE_CYC = 10,
    parameter int unsigned SR_MIN_CYC    = 25_000,
    parameter int unsigned SR_EXIT_CYC   = 28,
    parameter int unsigned ROWS          = 1024,
    localparam int unsigned ROW_W = $clog2(ROWS),
    localparam int unsigned OWED_W = $clog2(OWED_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             ref_req,
    input  logic             ref_gnt,
    input  logic             seq_idle,
    input  logic             self_refresh_req,
    output logic             self_refresh_ack,
    output logic             init_done,
    output logic             ras_n,
    output logic             ucas_n,
    output logic             lcas_n,
    output logic             we_n,
    output logic [ROW_W-1:0] row_addr
);
    logic              tick;
    logic              timer_hold;
    logic              owed_dec;
    logic              owed_nz;
    logic              row_adv;
    logic              cas_n;
    logic [OWED_W-1:0] owed_cnt;

    rfm_interval_timer #(.INTERVAL_CYC(INTERVAL_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (timer_hold),
        .tick  (tick)
    );

    rfm_owed_counter #(.OWED_MAX(OWED_MAX)) u_owed (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (tick),
        .dec     (owed_dec),
        .count   (owed_cnt),
        .nonzero (owed_nz)
    );

    rfm_row_counter #(.ROWS(ROWS)) u_row (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (row_adv),
        .row   (row_addr)
    );

    rfm_cycle_fsm #(
        .RAS_ONLY      (RAS_ONLY),
        .INIT_WAIT_CYC (INIT_WAIT_CYC),
        .INIT_CYCLES   (INIT_CYCLES),
        .CAS_SETUP_CYC (CAS_SETUP_CYC),
        .RAS_LOW_CYC   (RAS_LOW_CYC),
        .PRECHARGE_CYC (PRECHARGE_CYC),
        .SR_MIN_CYC    (SR_MIN_CYC),
        .SR_EXIT_CYC   (SR_EXIT_CYC),
        .ROWS          (ROWS)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_gnt    (ref_gnt),
        .seq_idle   (seq_idle),
        .sr_req     (self_refresh_req),
        .owed_nz    (owed_nz),
        .ref_req    (ref_req),
        .ras_n      (ras_n),
        .cas_n      (cas_n),
        .sr_ack     (self_refresh_ack),
        .init_done  (init_done),
        .timer_hold (timer_hold),
        .owed_dec   (owed_dec),
        .row_adv    (row_adv)
    );

    assign ucas_n = cas_n;
    assign lcas_n = cas_n;
    assign we_n   = 1'b1;
endmodule

// File: rtl/rfm_checker.sv
module rfm_checker #(
    parameter int unsigned OWED_MAX = 8,
    parameter int unsigned OW       = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ras_n,
    input logic          ucas_n,
    input logic          lcas_n,
    input logic          ref_req,
    input logic          sr_ack,
    input logic          init_done,
    input logic [OW-1:0] owed_cnt
);
    a_r3_cas_leads_ras: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) && !ucas_n) |-> ($past(!ucas_n) && !lcas_n));

    a_r3_ras_low_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |=> !ras_n);

    a_r3_precharge_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |=> ras_n);

    a_r3_cas_pair: assert property (@(posedge clk) disable iff (!rst_n)
        ucas_n == lcas_n);

    a_r12_owner: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n || !ucas_n || !lcas_n) |-> ref_req);

    a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        owed_cnt <= OW'(OWED_MAX));

    a_r8_ack_in_sr: assert property (@(posedge clk) disable iff (!rst_n)
        sr_ack |-> (!ras_n && !ucas_n));

    a_r2_ack_after_init: assert property (@(posedge clk) disable iff (!rst_n)
        sr_ack |-> init_done);

    a_r9_exit_raises_ras: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sr_ack) |-> ras_n);

    a_r1_quiet_before_init: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_done && !ref_req) |-> (ras_n && ucas_n));
endmodule

bind dram_refresh_mgr rfm_checker #(.OWED_MAX(OWED_MAX), .OW(OWED_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ras_n     (ras_n),
    .ucas_n    (ucas_n),
    .lcas_n    (lcas_n),
    .ref_req   (ref_req),
    .sr_ack    (self_refresh_ack),
    .init_done (init_done),
    .owed_cnt  (owed_cnt)
);

// File: tb/dram_refresh_mgr_test.sv
`timescale 1ns/1ps

module rfm_pin_watch #(
    parameter int CSR     = 2,
    parameter int RAS_MIN = 4,
    parameter int ROWS    = 16,
    parameter int RW      = 4
) (
    input  logic          clk,
    input  logic          ras_n,
    input  logic          ucas_n,
    input  logic          lcas_n,
    input  logic          ref_req,
    input  logic [RW-1:0] row,
    output int            falls,
    output int            cbr_falls,
    output int            shape_err,
    output int            row_err,
    output int            low_run,
    output int            high_at_fall
);
    int   cas_run  = 0;
    int   high_run = 0;
    int   exp_row  = 0;
    logic ras_p    = 1'b1;
    logic cbr_cyc  = 1'b0;

    initial begin
        falls = 0; cbr_falls = 0; shape_err = 0; row_err = 0;
        low_run = 0; high_at_fall = 0;
    end

    always @(negedge clk) begin
        if (ucas_n != lcas_n) shape_err++;
        if ((!ras_n || !ucas_n) && !ref_req) shape_err++;
        if (ras_p && !ras_n) begin
            falls++;
            high_at_fall = high_run;
            if (!ucas_n) begin
                cbr_falls++;
                cbr_cyc = 1'b1;
                if (cas_run < CSR) shape_err++;
            end else begin
                cbr_cyc = 1'b0;
                if (int'(row) != exp_row) row_err++;
                exp_row = (exp_row + 1) % ROWS;
            end
        end
        if (!ras_p && ras_n && low_run < RAS_MIN) shape_err++;
        if (!ras_n && cbr_cyc && ucas_n) shape_err++;
        if (ras_n) begin high_run++; low_run = 0; end
        else       begin low_run++;  high_run = 0; end
        if (!ucas_n && ras_n) cas_run++;
        else if (ucas_n)      cas_run = 0;
        ras_p = ras_n;
    end
endmodule

module dram_refresh_mgr_test;
    localparam int INIT_WAIT = 200;
    localparam int INTERVAL  = 400;
    localparam int CSR       = 2;
    localparam int RASLO     = 4;
    localparam int RP        = 3;
    localparam int SRMIN     = 60;
    localparam int SREXIT    = 5;
    localparam int NROWS     = 16;
    localparam int RW        = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic gnt_en = 1'b1, seq_idle = 1'b1, sr_req = 1'b0;
    logic ref_req, sr_ack, init_done, ras_n, ucas_n, lcas_n, we_n;
    logic [RW-1:0] row;
    logic sr_req_ro = 1'b0;
    logic ref_req_ro, sr_ack_ro, init_done_ro, ras_n_ro, ucas_n_ro, lcas_n_ro, we_n_ro;
    logic [RW-1:0] row_ro;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    dram_refresh_mgr #(
        .RAS_ONLY(1'b0), .INIT_WAIT_CYC(INIT_WAIT), .INIT_CYCLES(8), .INTERVAL_CYC(INTERVAL),
        .OWED_MAX(8), .CAS_SETUP_CYC(CSR), .RAS_LOW_CYC(RASLO), .PRECHARGE_CYC(RP),
        .SR_MIN_CYC(SRMIN), .SR_EXIT_CYC(SREXIT), .ROWS(NROWS)
    ) uut (
        .clk(clk), .rst_n(rst_n), .ref_req(ref_req), .ref_gnt(ref_req && gnt_en),
        .seq_idle(seq_idle), .self_refresh_req(sr_req), .self_refresh_ack(sr_ack),
        .init_done(init_done), .ras_n(ras_n), .ucas_n(ucas_n), .lcas_n(lcas_n),
        .we_n(we_n), .row_addr(row)
    );

    dram_refresh_mgr #(
        .RAS_ONLY(1'b1), .INIT_WAIT_CYC(INIT_WAIT), .INIT_CYCLES(8), .INTERVAL_CYC(INTERVAL),
        .OWED_MAX(8), .CAS_SETUP_CYC(CSR), .RAS_LOW_CYC(RASLO), .PRECHARGE_CYC(RP),
        .SR_MIN_CYC(SRMIN), .SR_EXIT_CYC(SREXIT), .ROWS(NROWS)
    ) uut_ro (
        .clk(clk), .rst_n(rst_n), .ref_req(ref_req_ro), .ref_gnt(ref_req_ro),
        .seq_idle(1'b1), .self_refresh_req(sr_req_ro), .self_refresh_ack(sr_ack_ro),
        .init_done(init_done_ro), .ras_n(ras_n_ro), .ucas_n(ucas_n_ro), .lcas_n(lcas_n_ro),
        .we_n(we_n_ro), .row_addr(row_ro)
    );

    int falls, cbr_falls, shape_err, row_err, low_run, high_at_fall;
    int falls_ro, cbr_ro, shape_ro, row_err_ro, low_ro, high_ro;

    rfm_pin_watch #(.CSR(CSR), .RAS_MIN(RASLO), .ROWS(NROWS), .RW(RW)) w_main (
        .clk(clk), .ras_n(ras_n), .ucas_n(ucas_n), .lcas_n(lcas_n), .ref_req(ref_req),
        .row(row), .falls(falls), .cbr_falls(cbr_falls), .shape_err(shape_err),
        .row_err(row_err), .low_run(low_run), .high_at_fall(high_at_fall)
    );

    rfm_pin_watch #(.CSR(CSR), .RAS_MIN(RASLO), .ROWS(NROWS), .RW(RW)) w_ro (
        .clk(clk), .ras_n(ras_n_ro), .ucas_n(ucas_n_ro), .lcas_n(lcas_n_ro), .ref_req(ref_req_ro),
        .row(row_ro), .falls(falls_ro), .cbr_falls(cbr_ro), .shape_err(shape_ro),
        .row_err(row_err_ro), .low_run(low_ro), .high_at_fall(high_ro)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            finish_run();
        end
    end

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(ras_n && ucas_n && lcas_n, "R1 strobes idle in reset", {ras_n, ucas_n, lcas_n}, 7);
        chk(!ref_req && !init_done, "R1 req/init low in reset", {ref_req, init_done}, 0);
        rst_n = 1'b1;
        repeat (INIT_WAIT - 10) @(negedge clk);
        chk(falls == 0 && !ref_req, "R1 quiet during power-up pause", falls, 0);
        chk(we_n == 1'b1, "R1 write enable held high", we_n, 1);
    endtask

    task automatic t_init();
        int gaps = 0;
        bit seen = 0;
        for (int i = 0; i < 600 && !init_done; i++) begin
            @(negedge clk);
            if (seen && !ref_req && !init_done) gaps++;
            if (ref_req) seen = 1;
        end
        chk(init_done, "R2 init_done rises", init_done, 1);
        chk(falls == 8 && cbr_falls == 8, "R2 eight init refresh cycles", falls, 8);
        chk(gaps == 0, "R12 request held across init burst", gaps, 0);
        chk(shape_err == 0, "R3 CAS-before-RAS cycle shape", shape_err, 0);
        chk(falls_ro == 8 && cbr_ro == 0, "R7 init cycles are RAS-only", cbr_ro, 0);
        chk(row_err_ro == 0, "R7 row order during init", row_err_ro, 0);
    endtask

    task automatic t_rate();
        int f0 = falls;
        repeat (10 * INTERVAL) @(negedge clk);
        chk(falls - f0 >= 9 && falls - f0 <= 11, "R5 refresh rate over window", falls - f0, 10);
    endtask

    task automatic t_postpone();
        int f0;
        repeat (20) @(negedge clk);
        gnt_en = 1'b0;
        f0 = falls;
        repeat (12 * INTERVAL) @(negedge clk);
        chk(falls == f0 && ref_req && ras_n && ucas_n, "R4 no strobes without grant", falls - f0, 0);
        gnt_en = 1'b1;
        repeat (150) @(negedge clk);
        chk(falls - f0 >= 8 && falls - f0 <= 9, "R6 catch-up burst saturates", falls - f0, 8);
        chk(shape_err == 0, "R3 cycle shape after catch-up", shape_err, 0);
    endtask

    task automatic t_self_refresh();
        int f0;
        int lr;
        int gaps = 0;
        bit ok = 0;
        seq_idle = 1'b0;
        sr_req   = 1'b1;
        f0 = falls;
        repeat (900) @(negedge clk);
        chk(!sr_ack && falls > f0, "R8 no entry while sequencer busy", sr_ack, 0);
        seq_idle = 1'b1;
        for (int i = 0; i < 2000 && !ok; i++) begin
            @(negedge clk);
            if (sr_ack) ok = 1;
        end
        lr = low_run;
        chk(ok && lr >= SRMIN && !ucas_n, "R8 RAS held low before acknowledge", lr, SRMIN);
        f0 = falls;
        repeat (3 * INTERVAL) @(negedge clk);
        chk(falls == f0 && sr_ack && !ras_n, "R8 no refresh while in self-refresh", falls - f0, 0);
        sr_req = 1'b0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (falls == f0 && !ref_req) gaps++;
        end
        chk(falls - f0 == 1 && cbr_falls > 0, "R9 one refresh right after exit", falls - f0, 1);
        chk(high_at_fall >= SREXIT && gaps == 0, "R9 exit precharge with request held", high_at_fall, SREXIT);
        chk(!sr_ack && !ref_req, "R9 request released after exit refresh", ref_req, 0);
    endtask

    task automatic t_ras_only_sr();
        int f0 = falls_ro;
        int c0 = cbr_ro;
        bit ok = 0;
        sr_req_ro = 1'b1;
        for (int i = 0; i < 2000 && !ok; i++) begin
            @(negedge clk);
            if (sr_ack_ro) ok = 1;
        end
        chk(ok && (falls_ro - f0 == 17 || falls_ro - f0 == 18), "R10 full pass before entry",
            falls_ro - f0, 17);
        chk(cbr_ro - c0 == 1 && !ucas_n_ro, "R10 entry cycle is CAS-before-RAS", cbr_ro - c0, 1);
        f0 = falls_ro;
        sr_req_ro = 1'b0;
        repeat (300) @(negedge clk);
        chk(falls_ro - f0 == 16 && cbr_ro - c0 == 1, "R10 full pass after exit", falls_ro - f0, 16);
        chk(row_err_ro == 0 && shape_ro == 0, "R7 row order and shape overall", row_err_ro, 0);
    endtask

    initial begin
        t_reset();
        t_init();
        t_rate();
        t_postpone();
        t_self_refresh();
        t_ras_only_sr();
        chk(shape_err == 0, "R12 strobes only under request", shape_err, 0);
        finish_run();
    end
endmodule